// File: doc/BRIEF.md
# Packed Signed Halving Add/Subtract Unit

This unit is one execution slice of a processor datapath. It takes a 32-bit instruction word and two 32-bit operand values, and returns a packed SIMD result. The operand values come from the first source register (A) and the second source register (B). The unit treats each operand either as two signed 16-bit lanes or as four signed 8-bit lanes. In each lane it forms a signed sum or difference one bit wider than the lane, then shifts that value right by one. The halved value therefore always fits back into the lane. Two halfword operations are crossed: the high half of B pairs with the low half of A, and one lane adds while the other subtracts.

The instruction word carries a 4-bit condition field, checked against the N, Z, C and V flag inputs. It also carries a class field, an operation selector and three register indices. The two source indices are decoded combinationally, so a register file outside the unit can supply the operands in the same cycle. The result, the destination index and a write enable are registered and appear one cycle after the input strobe. The unit never changes the flags.

Top module: `halving_simd_unit`

## Requirements
- R1: `src_a_idx` shows instruction bits [19:16] and `src_b_idx` shows bits [3:0], combinationally. When `out_valid` is high, `dest_idx` holds bits [15:12] of the instruction accepted one cycle earlier.
- R2: `out_valid` is high in the cycle after each cycle in which `in_valid` was high, and low otherwise. Reset clears `out_valid`, `wr_en` and `result`.
- R3: Selector (bits [7:5]) 0 is the halfword add. Each 16-bit lane of the result is (A lane + B lane) >> 1, computed on signed values.
- R4: Selector 1 is the crossed add/subtract. The low lane is (A[15:0] − B[31:16]) >> 1 and the high lane is (A[31:16] + B[15:0]) >> 1.
- R5: Selector 2 is the crossed subtract/add. The low lane is (A[15:0] + B[31:16]) >> 1 and the high lane is (A[31:16] − B[15:0]) >> 1.
- R6: Selector 3 is the halfword subtract. Each 16-bit lane is (A lane − B lane) >> 1.
- R7: Selector 4 is the byte add and selector 7 is the byte subtract, on four signed 8-bit lanes. Byte k of the result comes only from byte k of A and byte k of B.
- R8: The intermediate value is one bit wider than the lane, so extreme inputs never wrap. The shift rounds toward negative infinity: 0x7FFF+0x7FFF gives 0x7FFF, 0x8000+0x8000 gives 0x8000, and 0x0000−0x0001 gives 0xFFFF.
- R9: Flags are packed as {N,Z,C,V} in bits [3:0]. Condition (bits [31:28]) 0xE always executes and 0xF never executes. Conditions 0x0 to 0xD mean EQ, NE, CS, CC, MI, PL, VS, VC, HI, LS, GE, LT, GT and LE, in that order, with their usual flag meanings.
- R10: Selectors 5 and 6 are not valid operations. For them `wr_en` is low and `result` is zero, while `out_valid` still follows R2.
- R11: The class field, bits [21:20], must equal the parameter `OP_CLASS` (default 2'b11). Any other value gives `wr_en` low and `result` zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction and operands are present this cycle |
| instr | input | 32 | Instruction word |
| opnd_a | input | 32 | Value of the first source register |
| opnd_b | input | 32 | Value of the second source register |
| flags | input | 4 | Condition flags {N,Z,C,V} |
| src_a_idx | output | 4 | First source register index |
| src_b_idx | output | 4 | Second source register index |
| out_valid | output | 1 | Registered result is present |
| result | output | 32 | Packed lane result; zero when no write |
| dest_idx | output | 4 | Destination register index |
| wr_en | output | 1 | Destination write enable |

## Verification
The unit has one register stage, so any internal fault shows at the ports in the cycle after the strobe. A wrong lane pairing, a swapped add/subtract choice or a missing sign extension corrupts one specific 16-bit or 8-bit field of `result`. The bench feeds inputs at the extreme signed values, so these faults appear as wraps or wrong rounding in that field. A wrong condition decode shows as `wr_en` set or cleared for one particular combination of condition code and flags. For that reason all 256 combinations are swept.

// File: rtl/hsa_pkg.sv
package hsa_pkg;

  // Operation selector values carried in instruction bits [7:5]
  typedef enum logic [2:0] {
    SEL_ADD_H  = 3'd0,
    SEL_ASX_H  = 3'd1,
    SEL_SAX_H  = 3'd2,
    SEL_SUB_H  = 3'd3,
    SEL_ADD_B  = 3'd4,
    SEL_RSV5   = 3'd5,
    SEL_RSV6   = 3'd6,
    SEL_SUB_B  = 3'd7
  } hsa_sel_e;

  // Decoded control for one instruction
  typedef struct packed {
    logic       op_ok;     // selector valid and class matches
    logic       byte_mode; // four 8-bit lanes
    logic       xchg;      // B halves crossed
    logic       sub_lo;    // low halfword lane subtracts
    logic       sub_hi;    // high halfword lane subtracts
    logic       sub_byte;  // byte lanes subtract
  } hsa_ctrl_t;

  // Condition test; flags packed {N,Z,C,V}
  function automatic logic cond_met(input logic [3:0] cc, input logic [3:0] f);
    logic n, z, c, v;
    {n, z, c, v} = f;
    case (cc)
      4'h0: cond_met = z;
      4'h1: cond_met = !z;
      4'h2: cond_met = c;
      4'h3: cond_met = !c;
      4'h4: cond_met = n;
      4'h5: cond_met = !n;
      4'h6: cond_met = v;
      4'h7: cond_met = !v;
      4'h8: cond_met = c && !z;
      4'h9: cond_met = !c || z;
      4'hA: cond_met = (n == v);
      4'hB: cond_met = (n != v);
      4'hC: cond_met = !z && (n == v);
      4'hD: cond_met = z || (n != v);
      4'hE: cond_met = 1'b1;
      default: cond_met = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/hsa_decode.sv
module hsa_decode
  import hsa_pkg::*;
#(
  parameter logic [1:0] OP_CLASS = 2'b11
) (
  input  logic [1:0] class_f,
  input  logic [2:0] sel_f,
  output hsa_ctrl_t  ctrl
);
  hsa_sel_e sel;
  assign sel = hsa_sel_e'(sel_f);

  always_comb begin
    ctrl = '0;
    case (sel)
      SEL_ADD_H: ctrl.op_ok = 1'b1;
      SEL_ASX_H: begin ctrl.op_ok = 1'b1; ctrl.xchg = 1'b1; ctrl.sub_lo = 1'b1; end
      SEL_SAX_H: begin ctrl.op_ok = 1'b1; ctrl.xchg = 1'b1; ctrl.sub_hi = 1'b1; end
      SEL_SUB_H: begin ctrl.op_ok = 1'b1; ctrl.sub_lo = 1'b1; ctrl.sub_hi = 1'b1; end
      SEL_ADD_B: begin ctrl.op_ok = 1'b1; ctrl.byte_mode = 1'b1; end
      SEL_SUB_B: begin ctrl.op_ok = 1'b1; ctrl.byte_mode = 1'b1; ctrl.sub_byte = 1'b1; end
      default:   ctrl = '0;
    endcase
    if (class_f != OP_CLASS) ctrl.op_ok = 1'b0;
  end
endmodule

// File: rtl/hsa_cond.sv
module hsa_cond
  import hsa_pkg::*;
(
  input  logic [3:0] cc,
  input  logic [3:0] flags,
  output logic       pass
);
  assign pass = cond_met(cc, flags);
endmodule

// File: rtl/hsa_lane.sv
module hsa_lane #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] r
);
  // Widen by one bit, add or subtract, keep the upper W bits (floor halving)
  function automatic logic [W-1:0] halve(input logic [W-1:0] x, input logic [W-1:0] y,
                                         input logic s);
    logic [W:0] wide;
    wide = s ? ({x[W-1], x} - {y[W-1], y}) : ({x[W-1], x} + {y[W-1], y});
    return wide[W:1];
  endfunction

  assign r = halve(a, b, sub);
endmodule

// File: rtl/halving_simd_unit.sv
module halving_simd_unit
  import hsa_pkg::*;
#(
  parameter int         DATA_W   = 32,
  parameter logic [1:0] OP_CLASS = 2'b11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [31:0]       instr,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [3:0]        flags,
  output logic [3:0]        src_a_idx,
  output logic [3:0]        src_b_idx,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic [3:0]        dest_idx,
  output logic              wr_en
);
  localparam int HALF_W = DATA_W / 2;
  localparam int BYTE_W = DATA_W / 4;

  assign src_a_idx = instr[19:16];
  assign src_b_idx = instr[3:0];

  logic unused_instr_bits;
  assign unused_instr_bits = ^{instr[27:22], instr[11:8], instr[4]};

  hsa_ctrl_t ctrl;
  logic      cond_pass;
  logic      exec_ok;

  hsa_decode #(.OP_CLASS(OP_CLASS)) u_decode (
    .class_f (instr[21:20]),
    .sel_f   (instr[7:5]),
    .ctrl    (ctrl)
  );

  hsa_cond u_cond (
    .cc    (instr[31:28]),
    .flags (flags),
    .pass  (cond_pass)
  );

  assign exec_ok = ctrl.op_ok && cond_pass;

  // Halfword lanes; crossed variants pair A half i with B half (1-i)
  logic [DATA_W-1:0] half_res;
  for (genvar i = 0; i < 2; i++) begin : g_half
    logic [HALF_W-1:0] b_pick;
    logic              do_sub;
    assign b_pick = ctrl.xchg ? opnd_b[(1-i)*HALF_W +: HALF_W] : opnd_b[i*HALF_W +: HALF_W];
    assign do_sub = (i == 0) ? ctrl.sub_lo : ctrl.sub_hi;
    hsa_lane #(.W(HALF_W)) u_lane (
      .a   (opnd_a[i*HALF_W +: HALF_W]),
      .b   (b_pick),
      .sub (do_sub),
      .r   (half_res[i*HALF_W +: HALF_W])
    );
  end

  // Byte lanes, straight pairing
  logic [DATA_W-1:0] byte_res;
  for (genvar k = 0; k < 4; k++) begin : g_byte
    hsa_lane #(.W(BYTE_W)) u_lane (
      .a   (opnd_a[k*BYTE_W +: BYTE_W]),
      .b   (opnd_b[k*BYTE_W +: BYTE_W]),
      .sub (ctrl.sub_byte),
      .r   (byte_res[k*BYTE_W +: BYTE_W])
    );
  end

  logic [DATA_W-1:0] lane_out;
  assign lane_out = ctrl.byte_mode ? byte_res : half_res;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      wr_en     <= 1'b0;
      result    <= '0;
      dest_idx  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        wr_en    <= exec_ok;
        result   <= exec_ok ? lane_out : '0;
        dest_idx <= instr[15:12];
      end else begin
        wr_en  <= 1'b0;
        result <= '0;
      end
    end
  end

  // Latency: one strobe in, one valid out a cycle later
  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_valid_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // Destination index travels with the result
  assert_dest_index_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && rst_n) |=> dest_idx == $past(instr[15:12]));
  // Writes only for a passing condition and a legal operation
  assert_write_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (out_valid && $past(exec_ok)));
  // Illegal selector or class never writes
  assert_no_illegal_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !ctrl.op_ok) |=> !wr_en);
  // Suppressed writes drive a zero result
  assert_zero_when_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> result == '0);
endmodule

// File: tb/test_halving_simd_unit.sv
module test_halving_simd_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] instr = '0;
  logic [31:0] opnd_a = '0;
  logic [31:0] opnd_b = '0;
  logic [3:0]  flags = '0;
  logic [3:0]  src_a_idx, src_b_idx, dest_idx;
  logic        out_valid, wr_en;
  logic [31:0] result;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;  // 200 MHz

  halving_simd_unit i_halving_simd_unit (
    .clk, .rst_n, .in_valid, .instr, .opnd_a, .opnd_b, .flags,
    .src_a_idx, .src_b_idx, .out_valid, .result, .dest_idx, .wr_en
  );

  // Instruction layout: cond[31:28], class[21:20], A[19:16], dst[15:12], sel[7:5], B[3:0]
  function automatic logic [31:0] mk(input logic [3:0] cc, input logic [1:0] cls,
                                     input logic [2:0] sel, input logic [3:0] ra,
                                     input logic [3:0] rd, input logic [3:0] rb);
    return {cc, 6'b011000, cls, ra, rd, 4'hF, sel, 1'b1, rb};
  endfunction

  // Reference arithmetic on plain integers
  function automatic logic [31:0] model(input logic [2:0] sel, input logic [31:0] a,
                                        input logic [31:0] b);
    int alo, ahi, blo, bhi, lo, hi, p, q, t;
    logic [31:0] r;
    alo = int'($signed(a[15:0]));  ahi = int'($signed(a[31:16]));
    blo = int'($signed(b[15:0]));  bhi = int'($signed(b[31:16]));
    r = '0;
    lo = 0; hi = 0;
    case (sel)
      3'd0: begin lo = alo + blo; hi = ahi + bhi; end
      3'd1: begin lo = alo - bhi; hi = ahi + blo; end
      3'd2: begin lo = alo + bhi; hi = ahi - blo; end
      3'd3: begin lo = alo - blo; hi = ahi - bhi; end
      default: ;
    endcase
    if (sel <= 3'd3) begin
      lo = lo >>> 1; hi = hi >>> 1;
      r = {hi[15:0], lo[15:0]};
    end else if (sel == 3'd4 || sel == 3'd7) begin
      for (int k = 0; k < 4; k++) begin
        p = int'($signed(a[8*k +: 8]));
        q = int'($signed(b[8*k +: 8]));
        t = (sel == 3'd4) ? (p + q) : (p - q);
        t = t >>> 1;
        r[8*k +: 8] = t[7:0];
      end
    end
    return r;
  endfunction

  function automatic bit cond_ref(input logic [3:0] cc, input logic [3:0] f);
    bit n, z, c, v, base;
    n = f[3]; z = f[2]; c = f[1]; v = f[0];
    case (cc[3:1])
      3'd0: base = z;
      3'd1: base = c;
      3'd2: base = n;
      3'd3: base = v;
      3'd4: base = c & ~z;
      3'd5: base = ~(n ^ v);
      3'd6: base = ~z & ~(n ^ v);
      default: base = 1'b1;
    endcase
    if (cc == 4'hF) return 1'b0;
    return cc[0] ? ~base : base;
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Drive one operation; outputs are checked at the next falling edge
  task automatic issue(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b,
                       input logic [3:0] f);
    @(negedge clk);
    instr = ins; opnd_a = a; opnd_b = b; flags = f; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  localparam int NV = 10;
  localparam logic [66:0] VEC [NV] = '{
    {3'd0, 32'h12345678, 32'h0F0F0F0F},
    {3'd0, 32'hFFFF0001, 32'hFFFF0000},
    {3'd1, 32'h7FFF8000, 32'h7FFF8000},
    {3'd1, 32'hA5A55A5A, 32'h13572468},
    {3'd2, 32'h80007FFF, 32'h80008000},
    {3'd2, 32'hDEADBEEF, 32'hCAFEF00D},
    {3'd3, 32'h00010000, 32'hFFFF0001},
    {3'd3, 32'h7FFF8000, 32'h80007FFF},
    {3'd4, 32'h807F01FF, 32'h807F01FF},
    {3'd7, 32'h7F8001FE, 32'h807F0203}
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R2: reset state
    check("R2", "reset out_valid", {31'b0, out_valid}, 32'h0);
    check("R2", "reset wr_en", {31'b0, wr_en}, 32'h0);
    check("R2", "reset result", result, 32'h0);
    rst_n = 1'b1;

    // R1: source indices are combinational
    instr = mk(4'hE, 2'b11, 3'd0, 4'h9, 4'h3, 4'hC);
    #1;
    check("R1", "src_a_idx", {28'b0, src_a_idx}, 32'h9);
    check("R1", "src_b_idx", {28'b0, src_b_idx}, 32'hC);

    // Table walk (R3..R7)
    for (int i = 0; i < NV; i++) begin
      logic [2:0] s;
      logic [3:0] rd;
      s = VEC[i][66:64];
      rd = 4'(i);
      issue(mk(4'hE, 2'b11, s, 4'h1, rd, 4'h2), VEC[i][63:32], VEC[i][31:0], 4'h0);
      check(s == 0 ? "R3" : s == 1 ? "R4" : s == 2 ? "R5" : s == 3 ? "R6" : "R7",
            "table result", result, model(s, VEC[i][63:32], VEC[i][31:0]));
      check("R1", "dest_idx", {28'b0, dest_idx}, {28'b0, rd});
      check("R2", "out_valid", {31'b0, out_valid}, 32'h1);
      @(negedge clk);
      check("R2", "out_valid drop", {31'b0, out_valid}, 32'h0);
    end

    // Hand-computed corners
    issue(mk(4'hE, 2'b11, 3'd0, 0, 1, 2), 32'h7FFF7FFF, 32'h7FFF7FFF, 0);
    check("R8", "max add", result, 32'h7FFF7FFF);
    issue(mk(4'hE, 2'b11, 3'd0, 0, 1, 2), 32'h80008000, 32'h80008000, 0);
    check("R8", "min add", result, 32'h80008000);
    issue(mk(4'hE, 2'b11, 3'd3, 0, 1, 2), 32'h80000000, 32'h7FFF0001, 0);
    check("R8", "sub floor", result, 32'h8000FFFF);
    issue(mk(4'hE, 2'b11, 3'd1, 0, 1, 2), 32'h00100020, 32'h00060004, 0);
    check("R4", "exchange asx", result, 32'h000A000D);
    issue(mk(4'hE, 2'b11, 3'd2, 0, 1, 2), 32'h00100020, 32'h00060004, 0);
    check("R5", "exchange sax", result, 32'h00060013);
    issue(mk(4'hE, 2'b11, 3'd4, 0, 1, 2), 32'h7F80FF01, 32'h7F80FF00, 0);
    check("R7", "byte add", result, 32'h7F80FF00);
    issue(mk(4'hE, 2'b11, 3'd7, 0, 1, 2), 32'h80000000, 32'h7F000001, 0);
    check("R7", "byte sub", result, 32'h800000FF);

    // R10: reserved selectors
    for (int s = 5; s <= 6; s++) begin
      issue(mk(4'hE, 2'b11, 3'(s), 0, 1, 2), 32'h11112222, 32'h33334444, 0);
      check("R10", "reserved wr_en", {31'b0, wr_en}, 32'h0);
      check("R10", "reserved result", result, 32'h0);
      check("R10", "reserved out_valid", {31'b0, out_valid}, 32'h1);
    end

    // R11: class mismatch
    for (int c = 0; c < 3; c++) begin
      issue(mk(4'hE, 2'(c), 3'd0, 0, 1, 2), 32'h00020002, 32'h00020002, 0);
      check("R11", "class wr_en", {31'b0, wr_en}, 32'h0);
      check("R11", "class result", result, 32'h0);
    end

    // R9: every condition against every flag set
    for (int cc = 0; cc < 16; cc++) begin
      for (int f = 0; f < 16; f++) begin
        bit go;
        go = cond_ref(4'(cc), 4'(f));
        issue(mk(4'(cc), 2'b11, 3'd0, 0, 5, 2), 32'h00040006, 32'h00020002, 4'(f));
        check("R9", "cond wr_en", {31'b0, wr_en}, {31'b0, go});
        check("R9", "cond result", result, go ? 32'h00030004 : 32'h0);
      end
    end

    // R2: reset mid-stream clears outputs
    issue(mk(4'hE, 2'b11, 3'd0, 0, 1, 2), 32'h00040004, 32'h00040004, 0);
    rst_n = 1'b0;
    @(negedge clk);
    check("R2", "reset clears wr_en", {31'b0, wr_en}, 32'h0);
    check("R2", "reset clears result", result, 32'h0);
    rst_n = 1'b1;

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule